// File: doc/BRIEF.md
# Isochronous Bus Cycle Timer

This block keeps the 32-bit time reference of a serial bus link layer. It has three cascaded fields. A sub-cycle offset advances once per link clock. A cycle count advances each time the offset completes a 125 µs cycle. A seconds field advances each time the cycle count completes one second. The same value serves two purposes. Software reads it. When this node is cycle master, the transmit logic takes it as the payload of the cycle-start message.

When another node is cycle master, every cycle-start the node receives overwrites the whole value, so local time follows the master. Between received messages, or when no message arrives, the fields keep counting on their own as long as counting is enabled. Software can write the value directly. An optional external-clock mode lets a separate 8 kHz strobe re-align the offset to the start of a cycle. A one-clock boundary pulse marks each cycle start, and the cycle-master logic uses it to launch transmission.

Top module: `cycle_timer`

## Requirements
- R1: After reset the timer value is 0 and the boundary pulse is low.
- R2: Bit positions of the value: seconds in 31:25, cycle count in 24:12, offset in 11:0. With runEn high, the offset rises by 1 on every clock edge. From 3071 it returns to 0 and carries one into the cycle count.
- R3: The cycle count returns from 7999 to 0 and carries one into seconds. Seconds return from 127 to 0. So 127/7999/3071 advances to all zeros.
- R4: With runEn low and no load and no external tick, the value holds.
- R5: With hostWrEn high, the value equals hostWrData after that clock edge. Counting resumes from that value on the following edge.
- R6: With isMaster low, rxStartValid loads rxStartData into the whole value on that edge.
- R7: With isMaster high, rxStartValid has no effect on the value.
- R8: When hostWrEn and a valid received load occur on the same edge, the host data wins.
- R9: With extClkMode high, extTick passes through two synchronizing flops and only a rising edge acts. The third clock edge after extTick is first sampled high clears the offset to 0 and advances the cycle count by one, carrying into seconds as a natural wrap would.
- R10: extTick has no effect while extClkMode is low. A level held high does not re-align again.
- R11: cycleBoundary is high for exactly the one cycle in which the value shows offset 0 after a natural wrap or an external re-alignment. It stays low after host or received loads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Link clock, one offset tick per edge |
| rstN | input | 1 | Active-low synchronous reset |
| runEn | input | 1 | Enables free-running counting |
| isMaster | input | 1 | High when this node is cycle master |
| extClkMode | input | 1 | Enables external 8 kHz re-alignment |
| extTick | input | 1 | Asynchronous external 8 kHz strobe |
| hostWrEn | input | 1 | Host write strobe |
| hostWrData | input | 32 | Host write value |
| rxStartValid | input | 1 | A received cycle-start carries data this cycle |
| rxStartData | input | 32 | Data field of the received cycle-start |
| timerValue | output | 32 | Current timer value, also the transmit payload |
| cycleBoundary | output | 1 | One-clock pulse at each cycle start |

## Verification
Free-running is tried from host-written starting points. Some start inside a cycle, so only the offset moves. Some start one tick before an offset wrap, so the carry into the count shows. Some start at a count wrap and at the all-ones wrap, so the carries into seconds and back to zero show. One long run crosses two cycle boundaries and confirms the mixed radix. Received loads are tried once as non-master and once as master, and once against a host write on the same edge. This separates the load, ignore and priority paths. External ticks are applied as a fresh edge, as a held level, and with the mode off. Together these separate edge detection from level sensing and confirm the count carry on re-alignment.

// File: rtl/cycle_timer_pkg.sv
package cycle_timer_pkg;
  parameter int OFFSET_W   = 12;
  parameter int COUNT_W    = 13;
  parameter int SEC_W      = 7;
  parameter int OFFSET_MOD = 3072;
  parameter int COUNT_MOD  = 8000;
  parameter int SEC_MOD    = 128;
  localparam int TIMER_W   = OFFSET_W + COUNT_W + SEC_W;

  typedef struct packed {
    logic hostLoad;
    logic rxLoad;
    logic extAlign;
    logic countEn;
  } timerStrobes_t;
endpackage

// File: rtl/cycle_timer_ctrl.sv
module cycle_timer_ctrl
  import cycle_timer_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          runEn,
  input  logic          isMaster,
  input  logic          extClkMode,
  input  logic          extTick,
  input  logic          hostWrEn,
  input  logic          rxStartValid,
  output timerStrobes_t strobes
);
  // syncQ[SYNC_STAGES-1] is the synchronized tick, syncQ[SYNC_STAGES] its previous value
  logic [SYNC_STAGES:0] syncQ;
  logic tickRise;

  always_ff @(posedge clk) begin
    if (!rstN) syncQ <= '0;
    else       syncQ <= {syncQ[SYNC_STAGES-1:0], extTick};
  end

  assign tickRise = syncQ[SYNC_STAGES-1] & ~syncQ[SYNC_STAGES];

  always_comb begin
    strobes.hostLoad = hostWrEn;
    strobes.rxLoad   = rxStartValid & ~isMaster & ~hostWrEn;
    strobes.extAlign = extClkMode & tickRise & ~strobes.hostLoad & ~strobes.rxLoad;
    strobes.countEn  = runEn;
  end
endmodule

// File: rtl/cycle_timer_dp.sv
module cycle_timer_dp
  import cycle_timer_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  timerStrobes_t      strobes,
  input  logic [TIMER_W-1:0] hostWrData,
  input  logic [TIMER_W-1:0] rxStartData,
  output logic [TIMER_W-1:0] timerValue,
  output logic               cycleBoundary
);
  localparam logic [OFFSET_W-1:0] OFF_LAST = OFFSET_W'(OFFSET_MOD - 1);
  localparam logic [COUNT_W-1:0]  CNT_LAST = COUNT_W'(COUNT_MOD - 1);
  localparam logic [SEC_W-1:0]    SEC_LAST = SEC_W'(SEC_MOD - 1);

  logic [OFFSET_W-1:0] offsetQ;
  logic [COUNT_W-1:0]  countQ, countStep;
  logic [SEC_W-1:0]    secQ, secStep;
  logic                boundaryQ;
  logic                offWrap, cntWrap, secWrap;

  always_comb begin
    offWrap   = offsetQ >= OFF_LAST;
    cntWrap   = countQ >= CNT_LAST;
    secWrap   = secQ >= SEC_LAST;
    countStep = cntWrap ? '0 : countQ + 1'b1;
    secStep   = cntWrap ? (secWrap ? '0 : secQ + 1'b1) : secQ;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      offsetQ   <= '0;
      countQ    <= '0;
      secQ      <= '0;
      boundaryQ <= 1'b0;
    end else begin
      boundaryQ <= 1'b0;
      if (strobes.hostLoad) begin
        {secQ, countQ, offsetQ} <= hostWrData;
      end else if (strobes.rxLoad) begin
        {secQ, countQ, offsetQ} <= rxStartData;
      end else if (strobes.extAlign) begin
        offsetQ   <= '0;
        countQ    <= countStep;
        secQ      <= secStep;
        boundaryQ <= 1'b1;
      end else if (strobes.countEn) begin
        if (offWrap) begin
          offsetQ   <= '0;
          countQ    <= countStep;
          secQ      <= secStep;
          boundaryQ <= 1'b1;
        end else begin
          offsetQ <= offsetQ + 1'b1;
        end
      end
    end
  end

  assign timerValue    = {secQ, countQ, offsetQ};
  assign cycleBoundary = boundaryQ;
endmodule

// File: rtl/cycle_timer.sv
module cycle_timer
  import cycle_timer_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        runEn,
  input  logic        isMaster,
  input  logic        extClkMode,
  input  logic        extTick,
  input  logic        hostWrEn,
  input  logic [31:0] hostWrData,
  input  logic        rxStartValid,
  input  logic [31:0] rxStartData,
  output logic [31:0] timerValue,
  output logic        cycleBoundary
);
  timerStrobes_t strobes;

  cycle_timer_ctrl #(.SYNC_STAGES(2)) u_ctrl (
    .clk(clk), .rstN(rstN), .runEn(runEn), .isMaster(isMaster),
    .extClkMode(extClkMode), .extTick(extTick), .hostWrEn(hostWrEn),
    .rxStartValid(rxStartValid), .strobes(strobes)
  );

  cycle_timer_dp u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .hostWrData(hostWrData),
    .rxStartData(rxStartData), .timerValue(timerValue), .cycleBoundary(cycleBoundary)
  );
endmodule

// File: rtl/cycle_timer_chk.sv
module cycle_timer_chk (
  input logic        clk,
  input logic        rstN,
  input logic        runEn,
  input logic        isMaster,
  input logic        extClkMode,
  input logic        hostWrEn,
  input logic [31:0] hostWrData,
  input logic        rxStartValid,
  input logic [31:0] rxStartData,
  input logic [31:0] timerValue,
  input logic        cycleBoundary
);
  logic quiet;
  assign quiet = !hostWrEn && !rxStartValid && !extClkMode;

  a_r2_offset_step: assert property (@(posedge clk) disable iff (!rstN)
    runEn && quiet && timerValue[11:0] < 12'd3071 |=> timerValue[11:0] == $past(timerValue[11:0]) + 12'd1);

  a_r3_full_wrap: assert property (@(posedge clk) disable iff (!rstN)
    runEn && quiet && timerValue == {7'd127, 13'd7999, 12'd3071} |=> timerValue == 32'd0);

  a_r4_hold: assert property (@(posedge clk) disable iff (!rstN)
    !runEn && quiet |=> $stable(timerValue));

  a_r5_host_load: assert property (@(posedge clk) disable iff (!rstN)
    hostWrEn |=> timerValue == $past(hostWrData));

  a_r6_rx_load: assert property (@(posedge clk) disable iff (!rstN)
    !hostWrEn && rxStartValid && !isMaster |=> timerValue == $past(rxStartData));

  a_r11_pulse_at_zero: assert property (@(posedge clk) disable iff (!rstN)
    cycleBoundary |-> timerValue[11:0] == 12'd0);

  a_r11_no_pulse_after_load: assert property (@(posedge clk) disable iff (!rstN)
    hostWrEn |=> !cycleBoundary);
endmodule

bind cycle_timer cycle_timer_chk u_chk (
  .clk(clk), .rstN(rstN), .runEn(runEn), .isMaster(isMaster), .extClkMode(extClkMode),
  .hostWrEn(hostWrEn), .hostWrData(hostWrData), .rxStartValid(rxStartValid),
  .rxStartData(rxStartData), .timerValue(timerValue), .cycleBoundary(cycleBoundary)
);

// File: tb/cycle_timer_tb.sv
module cycle_timer_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        runEn = 1'b0, isMaster = 1'b1, extClkMode = 1'b0, extTick = 1'b0;
  logic        hostWrEn = 1'b0, rxStartValid = 1'b0;
  logic [31:0] hostWrData = '0, rxStartData = '0;
  logic [31:0] timerValue;
  logic        cycleBoundary;
  int nChecks = 0, nFails = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  cycle_timer u_dut (
    .clk(clk), .rstN(rstN), .runEn(runEn), .isMaster(isMaster), .extClkMode(extClkMode),
    .extTick(extTick), .hostWrEn(hostWrEn), .hostWrData(hostWrData),
    .rxStartValid(rxStartValid), .rxStartData(rxStartData),
    .timerValue(timerValue), .cycleBoundary(cycleBoundary)
  );

  // {seconds, count, offset, cycles to run}
  localparam int VEC [6][4] = '{
    '{0,   0,    0,    5},
    '{0,   0,    3070, 3},
    '{5,   7999, 3071, 1},
    '{127, 7999, 3071, 2},
    '{3,   100,  3000, 200},
    '{64,  7998, 10,   7000}
  };

  function automatic logic [31:0] pk(input int s, input int c, input int o);
    return {7'(s), 13'(c), 12'(o)};
  endfunction

  function automatic logic [31:0] adv(input logic [31:0] v, input int n);
    logic [6:0] s; logic [12:0] c; logic [11:0] o;
    s = v[31:25]; c = v[24:12]; o = v[11:0];
    for (int k = 0; k < n; k++) begin
      if (o >= 12'd3071) begin
        o = '0;
        if (c >= 13'd7999) begin c = '0; s = s + 7'd1; end
        else c = c + 13'd1;
      end else o = o + 12'd1;
    end
    return {s, c, o};
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic hostWrite(input logic [31:0] d);
    hostWrData = d; hostWrEn = 1'b1;
    cyc(1);
    hostWrEn = 1'b0;
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nChecks++; nFails++;
      $display("FAIL watchdog expired");
      summary();
    end
  end

  initial begin
    logic [31:0] v, d;
    cyc(3);
    // R1 reset state
    check("R1 reset value", timerValue, 32'd0);
    check("R1 reset pulse", {31'd0, cycleBoundary}, 32'd0);
    rstN = 1'b1;
    runEn = 1'b1;

    // R2 R3 R5 free-running from written starting points
    for (int i = 0; i < 6; i++) begin
      v = pk(VEC[i][0], VEC[i][1], VEC[i][2]);
      hostWrite(v);
      check("R5 host load", timerValue, v);
      cyc(VEC[i][3]);
      check("R2/R3 count advance", timerValue, adv(v, VEC[i][3]));
    end

    // R11 boundary pulse around a natural wrap
    hostWrite(pk(2, 40, 3070));
    check("R11 no pulse after load", {31'd0, cycleBoundary}, 32'd0);
    cyc(1);
    check("R11 no pulse before wrap", {31'd0, cycleBoundary}, 32'd0);
    cyc(1);
    check("R11 pulse at wrap", {31'd0, cycleBoundary}, 32'd1);
    check("R2 carry into count", timerValue, pk(2, 41, 0));
    cyc(1);
    check("R11 pulse one cycle", {31'd0, cycleBoundary}, 32'd0);

    // R4 hold with runEn low
    hostWrite(pk(9, 1234, 777));
    runEn = 1'b0;
    cyc(10);
    check("R4 hold", timerValue, pk(9, 1234, 777));
    runEn = 1'b1;

    // R6 received load as non-master
    isMaster = 1'b0;
    d = pk(77, 4321, 2000);
    rxStartData = d; rxStartValid = 1'b1;
    cyc(1);
    rxStartValid = 1'b0;
    check("R6 rx load", timerValue, d);
    cyc(4);
    check("R6 resume after rx", timerValue, adv(d, 4));

    // R7 received data ignored as master
    isMaster = 1'b1;
    v = timerValue;
    rxStartData = pk(1, 2, 3); rxStartValid = 1'b1;
    cyc(1);
    rxStartValid = 1'b0;
    check("R7 rx ignored", timerValue, adv(v, 1));

    // R8 host wins over received load
    isMaster = 1'b0;
    rxStartData = pk(10, 10, 10); rxStartValid = 1'b1;
    hostWrData = pk(20, 20, 20); hostWrEn = 1'b1;
    cyc(1);
    rxStartValid = 1'b0; hostWrEn = 1'b0;
    check("R8 host priority", timerValue, pk(20, 20, 20));
    isMaster = 1'b1;

    // R9 external re-alignment with count and seconds carry
    extClkMode = 1'b1;
    hostWrite(pk(10, 7999, 50));
    extTick = 1'b1;
    cyc(2);
    check("R9 before align", timerValue, pk(10, 7999, 52));
    cyc(1);
    check("R9 aligned value", timerValue, pk(11, 0, 0));
    check("R11 pulse on align", {31'd0, cycleBoundary}, 32'd1);
    // R10 held level does not realign
    cyc(10);
    check("R10 held tick", timerValue, pk(11, 0, 10));
    extTick = 1'b0;
    cyc(3);

    // R10 tick ignored when mode off
    extClkMode = 1'b0;
    v = timerValue;
    extTick = 1'b1;
    cyc(2);
    extTick = 1'b0;
    cyc(4);
    check("R10 mode off", timerValue, adv(v, 6));

    finished = 1'b1;
    summary();
  end
endmodule